// File: doc/BRIEF.md
# Three-Phase Gate Output Stage with Dead Time

This block holds the six gate-drive levels of a three-phase bridge, an upper and a lower arm for each of the U, V and W phases. All levels are active-low: a 0 turns the arm on and a 1 turns it off. Software loads two six-bit level buffers through a small register port. A transfer trigger copies the first buffer into the current output stage and the second buffer into a staged slot behind it. When the external one-shot pulse falls, the staged level moves into the current stage. A read of either buffer returns the shift stage, not the last value written.

Between the current stage and the pins sit two protections. The first is an interlock that turns off both arms of a phase whenever both arms would be commanded on. The second is a per-arm dead-time counter. A turn-off reaches the pin on the next clock. A turn-on waits for a programmable number of clock-enable ticks. The timers that make the trigger, the one-shot pulse and the tick are outside this block.

Top module: `tphase_gate_out`

## Requirements
- R1: While reset is low, and on the first clock after it, every gate output is 1 (off). Both shift stages and both buffers reset to all ones, so both reads return 8'h3F.
- R2: A buffer write (wr_sel 0 selects buffer 0, 1 selects buffer 1) does not change the read data or the outputs until a transfer trigger arrives.
- R3: A transfer trigger at a clock edge loads the current stage from buffer 0 and the staged slot from buffer 1. Read select 0 then returns the current stage and read select 1 returns the staged slot.
- R4: The staged slot moves into the current stage at the clock edge where the one-shot input is sampled low after being high. A rising edge of the one-shot input has no effect.
- R5: Bit k of the current stage drives gate_n[k]. The bit order is: bit 0 U upper, bit 1 U lower, bit 2 V upper, bit 3 V lower, bit 4 W upper, bit 5 W lower. A value of 0 means on.
- R6: If both bits of one phase in the current stage are 0, both gate outputs of that phase are 1. The two gate outputs of a phase are never 0 together.
- R7: When an arm is commanded off, its gate output becomes 1 one clock after the current stage changes.
- R8: With dead time disabled, a turn-on reaches the gate output one clock after the current stage changes.
- R9: With dead time enabled, a turn-on reaches the gate output at the clock edge carrying the (dt_load+1)-th tick after the current stage changes. Clock edges without a tick do not count.
- R10: If an arm is commanded off while its turn-on is still waiting, the wait is abandoned. A later turn-on starts the full count again.
- R11: If a transfer trigger and a one-shot falling edge occur in the same cycle, the transfer trigger takes priority.
- R12: Read data bits 7 and 6 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 1 | Buffer selector for writes (0 or 1) |
| wr_data | input | 6 | Level pattern to store |
| rd_sel | input | 1 | 0 reads the current stage, 1 reads the staged slot |
| rd_data | output | 8 | Read data, bits 7:6 zero |
| xfer_trig | input | 1 | Transfer trigger pulse |
| os_pulse | input | 1 | One-shot pulse; its falling edge advances the stage |
| tick | input | 1 | Clock enable for the dead-time counters |
| dt_en | input | 1 | Dead-time enable |
| dt_load | input | DT_W | Dead-time reload value |
| gate_n | output | 6 | Active-low gate drives |

## Verification
If a shift stage held a wrong value, the read port would show it one clock after the event that loaded it. The gate pins would show it one clock later than that. A dead-time counter that reloads wrongly, or that counts while there is no tick, would move a turn-on edge earlier or later by whole ticks. The bench's per-cycle model flags that on the first cycle where the edge lands differently. A broken interlock would show both arms of one phase low together in a single cycle, and both the model comparison and the shoot-through assertion would catch it.

// File: rtl/tpg_pkg.sv
// Shared constants and types for the three-phase gate output stage.
package tpg_pkg;
    localparam int NPH   = 3;            // phases U, V, W
    localparam int NARM  = 2 * NPH;      // upper+lower per phase
    localparam int RD_W  = 8;            // register read width
    typedef logic [NARM-1:0] arm_vec_t;  // bit 2p = upper, 2p+1 = lower
endpackage

// File: rtl/tpg_shift_stage.sv
// Two level buffers feeding a two-deep output shift stage.
// Assumes: xfer_trig and os_pulse are synchronous to clk; the one-shot
// falling edge is detected against the previous sampled value.
module tpg_shift_stage
    import tpg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  arm_vec_t        wr_data,
    input  logic            xfer_trig,
    input  logic            os_pulse,
    input  logic            rd_sel,
    output logic [RD_W-1:0] rd_data,
    output arm_vec_t        cur_lvl,
    output arm_vec_t        buf0_lvl
);
    arm_vec_t buf0_q, buf1_q, stage_q, staged_q;
    logic     os_q;
    logic     os_fall;

    // One-shot falling edge: high last cycle, low now.
    assign os_fall = os_q & ~os_pulse;

    // Buffer writes, edge history, and stage advance (transfer has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf0_q   <= '1;
            buf1_q   <= '1;
            stage_q  <= '1;
            staged_q <= '1;
            os_q     <= 1'b0;
        end else begin
            if (wr_en && !wr_sel) buf0_q <= wr_data;
            if (wr_en &&  wr_sel) buf1_q <= wr_data;
            os_q <= os_pulse;
            if (xfer_trig) begin
                stage_q  <= buf0_q;
                staged_q <= buf1_q;
            end else if (os_fall) begin
                stage_q  <= staged_q;
            end
        end
    end

    // Reads return the shift stage, zero-extended.
    always_comb begin
        rd_data = '0;
        rd_data[NARM-1:0] = rd_sel ? staged_q : stage_q;
    end

    assign cur_lvl  = stage_q;
    assign buf0_lvl = buf0_q;
endmodule

// File: rtl/tpg_interlock.sv
// Per-phase shoot-through guard: both arms low -> both forced high.
// Assumes: even bit is upper arm, odd bit is lower arm of the same phase.
module tpg_interlock
    import tpg_pkg::*;
(
    input  arm_vec_t lvl_in,
    output arm_vec_t lvl_out
);
    for (genvar p = 0; p < NPH; p++) begin : g_phase
        logic both_on;
        // Detect a phase whose two arms are both commanded on.
        always_comb begin
            both_on = ~lvl_in[2*p] & ~lvl_in[2*p+1];
            lvl_out[2*p]   = lvl_in[2*p]   | both_on;
            lvl_out[2*p+1] = lvl_in[2*p+1] | both_on;
        end
    end
endmodule

// File: rtl/tpg_deadtime_arm.sv
// One arm's output register with turn-on delay.
// Turn-off is immediate; turn-on waits dt_load+1 ticks when dt_en is set.
// Assumes: dt_load is stable while an arm is waiting.
module tpg_deadtime_arm #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            dt_en,
    input  logic [DT_W-1:0] dt_load,
    input  logic            cmd_n,
    output logic            gate_n
);
    logic [DT_W-1:0] cnt_q;
    logic            out_q;

    // Output level and delay counter; the counter reloads whenever it is not waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
            cnt_q <= '0;
        end else if (cmd_n) begin
            out_q <= 1'b1;
            cnt_q <= dt_load;
        end else if (out_q) begin
            if (!dt_en) begin
                out_q <= 1'b0;
            end else if (tick) begin
                if (cnt_q == '0) out_q <= 1'b0;
                else             cnt_q <= cnt_q - 1'b1;
            end
        end else begin
            cnt_q <= dt_load;
        end
    end

    assign gate_n = out_q;
endmodule

// File: rtl/tphase_gate_out.sv
// Three-phase gate output stage: buffers, shift stage, interlock and
// per-arm dead time. Assumes all inputs are synchronous to clk.
module tphase_gate_out
    import tpg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [5:0]      wr_data,
    input  logic            rd_sel,
    output logic [7:0]      rd_data,
    input  logic            xfer_trig,
    input  logic            os_pulse,
    input  logic            tick,
    input  logic            dt_en,
    input  logic [DT_W-1:0] dt_load,
    output logic [5:0]      gate_n
);
    arm_vec_t cur_lvl, buf0_lvl, cmd_n;

    tpg_shift_stage u_shift (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .xfer_trig(xfer_trig), .os_pulse(os_pulse),
        .rd_sel(rd_sel), .rd_data(rd_data), .cur_lvl(cur_lvl),
        .buf0_lvl(buf0_lvl)
    );

    tpg_interlock u_lock (
        .lvl_in(cur_lvl), .lvl_out(cmd_n)
    );

    for (genvar k = 0; k < NARM; k++) begin : g_arm
        tpg_deadtime_arm #(.DT_W(DT_W)) u_arm (
            .clk(clk), .rst_n(rst_n), .tick(tick), .dt_en(dt_en),
            .dt_load(dt_load), .cmd_n(cmd_n[k]), .gate_n(gate_n[k])
        );
    end
endmodule

// File: rtl/tpg_checker.sv
// Assertion checker for tphase_gate_out, attached by bind.
module tpg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_trig,
    input logic       dt_en,
    input logic [7:0] rd_data,
    input logic [5:0] gate_n,
    input logic [5:0] cmd_n,
    input logic [5:0] cur_lvl,
    input logic [5:0] buf0_lvl
);
    AST_RESET_OFF: assert property (@(posedge clk) !rst_n |=> (gate_n == 6'h3F)); // R1
    AST_XFER_LOADS: assert property (@(posedge clk) disable iff (!rst_n) xfer_trig |=> (cur_lvl == $past(buf0_lvl))); // R3
    AST_NO_SHOOT_U: assert property (@(posedge clk) disable iff (!rst_n) (gate_n[0] | gate_n[1])); // R6
    AST_NO_SHOOT_V: assert property (@(posedge clk) disable iff (!rst_n) (gate_n[2] | gate_n[3])); // R6
    AST_NO_SHOOT_W: assert property (@(posedge clk) disable iff (!rst_n) (gate_n[4] | gate_n[5])); // R6
    AST_OFF_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_n != 6'd0) |=> ((gate_n & $past(cmd_n)) == $past(cmd_n))); // R7
    AST_NO_DT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) !dt_en |=> (gate_n == $past(cmd_n))); // R8
    AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_data[7:6] == 2'b00)); // R12
endmodule

bind tphase_gate_out tpg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_trig(xfer_trig), .dt_en(dt_en),
    .rd_data(rd_data), .gate_n(gate_n), .cmd_n(cmd_n),
    .cur_lvl(cur_lvl), .buf0_lvl(buf0_lvl)
);

// File: tb/tb_tphase_gate_out.sv
module tb_tphase_gate_out;
    localparam int DT_W = 8;
    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0, wr_sel = 0, rd_sel = 0, xfer_trig = 0, os_pulse = 0;
    logic tick = 0, dt_en = 0;
    logic [5:0] wr_data = '0;
    logic [DT_W-1:0] dt_load = '0;
    logic [7:0] rd_data;
    logic [5:0] gate_n;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    tphase_gate_out #(.DT_W(DT_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .xfer_trig(xfer_trig), .os_pulse(os_pulse), .tick(tick),
        .dt_en(dt_en), .dt_load(dt_load), .gate_n(gate_n)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    int m_b[2], m_cur, m_nxt, m_g[6], m_c[6];
    bit m_osd;
    always @(posedge clk) begin
        int cmd[6];
        int b0, b1, cur, nxt;
        bit fall;
        b0 = m_b[0]; b1 = m_b[1]; cur = m_cur; nxt = m_nxt;
        if (!rst_n) begin
            m_b[0] = 63; m_b[1] = 63; m_cur = 63; m_nxt = 63; m_osd = 0;
            foreach (m_g[k]) begin m_g[k] = 1; m_c[k] = 0; end
        end else begin
            for (int p = 0; p < 3; p++) begin
                bit up, lo;
                up = cur[2*p]; lo = cur[2*p+1];
                if (!up && !lo) begin up = 1; lo = 1; end
                cmd[2*p] = up; cmd[2*p+1] = lo;
            end
            for (int k = 0; k < 6; k++) begin
                if (cmd[k] == 1) begin m_g[k] = 1; m_c[k] = dt_load; end
                else if (m_g[k] == 1) begin
                    if (!dt_en) m_g[k] = 0;
                    else if (tick) begin
                        if (m_c[k] == 0) m_g[k] = 0; else m_c[k]--;
                    end
                end else m_c[k] = dt_load;
            end
            fall = m_osd && !os_pulse;
            m_osd = os_pulse;
            if (xfer_trig) begin m_cur = b0; m_nxt = b1; end
            else if (fall) m_cur = nxt;
            if (wr_en) m_b[wr_sel] = wr_data;
        end
        #1;
        begin
            int eg, er;
            eg = 0;
            for (int k = 0; k < 6; k++) eg |= (m_g[k] << k);
            er = rd_sel ? m_nxt : m_cur;
            chk("R5 model gate", {2'b00, gate_n}, eg[7:0]);
            chk("R2 model read", rd_data, er[7:0]);
        end
    end

    task automatic cyc(int n); repeat (n) @(negedge clk); endtask
    task automatic wbuf(bit sel, logic [5:0] v);
        wr_en = 1; wr_sel = sel; wr_data = v; cyc(1); wr_en = 0;
    endtask
    task automatic rd(bit sel, string tag, logic [7:0] exp);
        rd_sel = sel; #1; chk(tag, rd_data, exp);
    endtask

    initial begin
        cyc(3);
        chk("R1 gates off", {2'b00, gate_n}, 8'h3F);
        rd(0, "R1 R12 read cur", 8'h3F);
        rd(1, "R1 R12 read staged", 8'h3F);
        rst_n = 1;
        cyc(1);
        chk("R1 after release", {2'b00, gate_n}, 8'h3F);
        // R2/R3/R5/R8: load buffers, transfer, dead time off
        wbuf(0, 6'h3E);
        wbuf(1, 6'h3D);
        rd(0, "R2 write not visible", 8'h3F);
        chk("R2 gates unchanged", {2'b00, gate_n}, 8'h3F);
        xfer_trig = 1; cyc(1); xfer_trig = 0;
        rd(0, "R3 cur from buf0", 8'h3E);
        rd(1, "R3 staged from buf1", 8'h3D);
        chk("R8 not yet", {2'b00, gate_n}, 8'h3F);
        rd_sel = 0;
        cyc(1);
        chk("R5 R8 U upper on", {2'b00, gate_n}, 8'h3E);
        // R4: rising edge ignored, falling edge advances
        os_pulse = 1; cyc(1); os_pulse = 0;
        rd(0, "R4 rise ignored", 8'h3E);
        cyc(1);
        rd(0, "R4 fall advances", 8'h3D);
        cyc(1);
        chk("R7 R8 swap arms", {2'b00, gate_n}, 8'h3D);
        // R6: interlock
        wbuf(0, 6'h3C);
        xfer_trig = 1; cyc(1); xfer_trig = 0;
        cyc(1);
        chk("R6 both forced off", {2'b00, gate_n}, 8'h3F);
        rd(0, "R6 stage keeps raw", 8'h3C);
        // R9: dead time 3 with tick every cycle
        dt_en = 1; dt_load = 3; tick = 1;
        wbuf(0, 6'h3B);
        xfer_trig = 1; cyc(1); xfer_trig = 0;
        cyc(3);
        chk("R9 still waiting", {2'b00, gate_n}, 8'h3F);
        cyc(1);
        chk("R9 on after load+1 ticks", {2'b00, gate_n}, 8'h3B);
        // R9: ticks gate the count
        wbuf(0, 6'h37);
        tick = 0;
        xfer_trig = 1; cyc(1); xfer_trig = 0;
        cyc(6);
        chk("R9 no tick no count", {2'b00, gate_n}, 8'h3F);
        tick = 1; cyc(4);
        chk("R9 resumes with ticks", {2'b00, gate_n}, 8'h37);
        // R10: abandon a waiting turn-on, then full restart
        dt_load = 6;
        wbuf(0, 6'h2F);
        xfer_trig = 1; cyc(1); xfer_trig = 0;
        cyc(1);
        wbuf(0, 6'h3F);
        xfer_trig = 1; cyc(1); xfer_trig = 0;
        cyc(2);
        chk("R10 cancelled", {2'b00, gate_n}, 8'h3F);
        wbuf(0, 6'h2F);
        xfer_trig = 1; cyc(1); xfer_trig = 0;
        cyc(6);
        chk("R10 full restart", {2'b00, gate_n}, 8'h3F);
        cyc(1);
        chk("R10 on after restart", {2'b00, gate_n}, 8'h2F);
        // R11: transfer beats one-shot fall
        dt_en = 0;
        wbuf(0, 6'h3E);
        os_pulse = 1; cyc(1);
        os_pulse = 0; xfer_trig = 1; cyc(1); xfer_trig = 0;
        rd(0, "R11 transfer wins", 8'h3E);
        cyc(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1 act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule